// File: doc/BRIEF.md
# SAR Converter Timing Sequencer

This block is the digital timing controller that sits in front of a successive-approximation analog macro. It builds a conversion clock enable from the peripheral clock by one of six power-of-two ratios. It then walks each conversion through the same phases: an optional supply-settling wait, a sample window during which the sampling switch is held closed, and a string of comparison steps. Each comparison step names the result bit being resolved, starting at the most significant bit. The block flags the final step as the end of the conversion.

A conversion starts in one of two ways. In software-start mode a start pulse launches it. In trigger-wait mode an external trigger launches it, and each triggered conversion first waits a fixed settling time of `PCLK_MHZ * STAB_US` peripheral cycles. In either mode the block runs one conversion or repeats them. When repeating with triggers, only the first trigger after enabling pays the settling wait. The ratio and sample-length settings are captured only while the converter is disabled. Clearing the enable stops any conversion at once.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset every output is 0. This includes the stored ratio code 000, the extension bit, and both sticky flags.
- R2: Ratio code c in 0..5 gives one `conv_tick` every 32 >> c peripheral cycles while converting. Codes 6 and 7 divide by 32 and set the sticky `cfg_err` flag when they are captured.
- R3: With the extension bit at 0, `sample_en` is high for 4 conversion clocks, followed by 12 `cmp_step` pulses. `cmp_bit` counts 11 down to 0 over those pulses. `conv_done` is high together with the final pulse, so a conversion lasts 16 conversion clocks.
- R4: With the extension bit at 1, the sample window lasts 8 conversion clocks and a conversion lasts 20.
- R5: In software-start mode, a `sw_start` pulse while enabled and idle starts sampling on the next cycle. A `sw_start` that arrives while busy is ignored.
- R6: In software-start repeat mode, a new sample window begins in the cycle right after `conv_done`, with no gap.
- R7: In trigger-wait single mode, every `hw_trig` accepted while idle is followed by exactly `PCLK_MHZ*STAB_US` cycles of `stab_wait` and then the sample window. `sw_start` has no effect in this mode.
- R8: In trigger-wait repeat mode, only the first accepted trigger after enabling is followed by the settling wait. Later triggers go straight to sampling.
- R9: In trigger-wait mode, an `hw_trig` that arrives while busy is ignored and sets the sticky `overrun` flag. This includes a trigger in the `conv_done` cycle.
- R10: A configuration write with `cfg_run`=0 returns the block to idle on the next cycle. It also re-arms the first-trigger settling wait.
- R11: A write to the ratio code or the extension bit while the converter is enabled leaves `ratio_q` and `ext_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_run | input | 1 | Converter enable value to write |
| cfg_cont | input | 1 | Repeat (1) or single (0) conversion |
| cfg_hwmode | input | 1 | Trigger-wait mode (1) or software start (0) |
| cfg_ratio | input | 3 | Clock ratio code to write |
| cfg_ext | input | 1 | Sample-window extension to write |
| sw_start | input | 1 | Software start pulse |
| hw_trig | input | 1 | Hardware trigger pulse |
| busy | output | 1 | A conversion sequence is in progress |
| stab_wait | output | 1 | Settling wait in progress |
| sample_en | output | 1 | Sampling switch enable for the analog macro |
| cmp_step | output | 1 | One-cycle strobe per comparison step |
| cmp_bit | output | $clog2(CMP_STEPS) | Result bit resolved by the current step |
| conv_tick | output | 1 | Conversion clock enable |
| conv_done | output | 1 | Last comparison step of a conversion |
| ratio_q | output | 3 | Captured ratio code |
| ext_q | output | 1 | Captured extension bit |
| cfg_err | output | 1 | Sticky flag for a reserved ratio code |
| overrun | output | 1 | Sticky flag for a trigger ignored while busy |

## Verification
The sharpest collision is a trigger that lands in the same cycle as `conv_done`. The sequence decides in that cycle whether to go idle or restart, and the trigger must count as an overrun, not as a new start. The bench counts cycles from a triggered start through the settling wait, the sample window and the comparison steps, and places a second trigger exactly in that cycle. The cycle reference model, compared on every clock, then expects `overrun` to rise and the block to come to rest idle. A second overlap is a disabling write issued during sampling. The model requires the next cycle to be idle, and requires the next trigger to pay the settling wait again.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_STAB   = 2'd1,
    PH_SAMPLE = 2'd2,
    PH_CMP    = 2'd3
  } adc_phase_e;

  localparam int unsigned DIV_MAX = 32;
  localparam int unsigned DIV_W   = $clog2(DIV_MAX);
  localparam logic [2:0]  RATIO_TOP = 3'd5;

  // Peripheral cycles per conversion clock for a ratio code.
  function automatic logic [DIV_W:0] div_ratio(input logic [2:0] code);
    logic [DIV_W:0] r;
    r = (DIV_W+1)'(DIV_MAX);
    if (code <= RATIO_TOP) r = r >> code;
    return r;
  endfunction

  function automatic logic ratio_reserved(input logic [2:0] code);
    return code > RATIO_TOP;
  endfunction

  // Settling wait in peripheral cycles.
  function automatic int unsigned stab_cycles(input int unsigned mhz, input int unsigned us);
    return mhz * us;
  endfunction

endpackage

// File: rtl/adc_cfg_regs.sv
`timescale 1ns/1ps
module adc_cfg_regs import adc_seq_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       run_in,
  input  logic       cont_in,
  input  logic       hw_in,
  input  logic [2:0] ratio_in,
  input  logic       ext_in,
  output logic       run_q,
  output logic       cont_q,
  output logic       hw_q,
  output logic [2:0] ratio_q,
  output logic       ext_q,
  output logic       cfg_err,
  output logic       halt
);

  logic timing_wr;

  // timing fields accepted only while the converter is stopped
  assign timing_wr = we & ~run_q;
  assign halt      = (we & ~run_in) | ~run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cont_q  <= 1'b0;
      hw_q    <= 1'b0;
      ratio_q <= 3'd0;
      ext_q   <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      if (we) begin
        run_q  <= run_in;
        cont_q <= cont_in;
        hw_q   <= hw_in;
      end
      if (timing_wr) begin
        ratio_q <= ratio_in;
        ext_q   <= ext_in;
        if (ratio_reserved(ratio_in)) cfg_err <= 1'b1;
      end
    end
  end

  assert_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> ($stable(ratio_q) && $stable(ext_q)));

  assert_err_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

endmodule

// File: rtl/adc_clk_div.sv
`timescale 1ns/1ps
module adc_clk_div import adc_seq_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [2:0] ratio,
  output logic       tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   div;
  logic [DIV_W-1:0] lim;

  assign div  = div_ratio(ratio);
  assign lim  = DIV_W'(div - (DIV_W+1)'(1));
  assign tick = ~clr & (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr | tick) cnt <= '0;
    else                 cnt <= cnt + DIV_W'(1);
  end

  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lim != '0) |=> !tick);

endmodule

// File: rtl/adc_phase_fsm.sv
`timescale 1ns/1ps
module adc_phase_fsm import adc_seq_pkg::*; #(
  parameter  int unsigned STAB_CYC    = 32,
  parameter  int unsigned SAMPLE_BASE = 4,
  parameter  int unsigned SAMPLE_EXT  = 8,
  parameter  int unsigned CMP_STEPS   = 12,
  localparam int unsigned SW   = $clog2(STAB_CYC + 1),
  localparam int unsigned PMAX = (SAMPLE_EXT > CMP_STEPS) ? SAMPLE_EXT : CMP_STEPS,
  localparam int unsigned PW   = $clog2(PMAX + 1),
  localparam int unsigned BW   = $clog2(CMP_STEPS)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic          run_q,
  input  logic          cont_q,
  input  logic          hw_q,
  input  logic          ext_q,
  input  logic          sw_start,
  input  logic          hw_trig,
  input  logic          tick,
  output adc_phase_e    state,
  output logic          div_clr,
  output logic          sample_en,
  output logic          stab_wait,
  output logic          cmp_step,
  output logic          conv_done,
  output logic [BW-1:0] cmp_bit
);

  localparam logic [SW-1:0] STAB_LAST = SW'(STAB_CYC - 1);
  localparam logic [PW-1:0] CMP_LAST  = PW'(CMP_STEPS - 1);

  logic [SW-1:0] scnt;
  logic [PW-1:0] pcnt;
  logic [PW-1:0] samp_last;
  logic          first_pend;
  logic          start_sw, start_hw, need_stab;
  logic          stab_done, samp_done, cmp_done;

  assign samp_last = ext_q ? PW'(SAMPLE_EXT - 1) : PW'(SAMPLE_BASE - 1);
  assign start_sw  = (state == PH_IDLE) & run_q & ~hw_q & sw_start;
  assign start_hw  = (state == PH_IDLE) & run_q &  hw_q & hw_trig;
  assign need_stab = ~cont_q | first_pend;
  assign stab_done = (state == PH_STAB)   & (scnt == STAB_LAST);
  assign samp_done = (state == PH_SAMPLE) & tick & (pcnt == samp_last);
  assign cmp_done  = (state == PH_CMP)    & tick & (pcnt == CMP_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PH_IDLE;
      scnt       <= '0;
      pcnt       <= '0;
      first_pend <= 1'b1;
    end else if (halt) begin
      state      <= PH_IDLE;
      scnt       <= '0;
      pcnt       <= '0;
      first_pend <= 1'b1;
    end else begin
      case (state)
        PH_IDLE: begin
          scnt <= '0;
          pcnt <= '0;
          if (start_hw)      state <= need_stab ? PH_STAB : PH_SAMPLE;
          else if (start_sw) state <= PH_SAMPLE;
        end
        PH_STAB: begin
          if (stab_done) begin
            state <= PH_SAMPLE;
            pcnt  <= '0;
            if (cont_q) first_pend <= 1'b0;
          end else begin
            scnt <= scnt + SW'(1);
          end
        end
        PH_SAMPLE: begin
          if (samp_done) begin
            state <= PH_CMP;
            pcnt  <= '0;
          end else if (tick) begin
            pcnt <= pcnt + PW'(1);
          end
        end
        PH_CMP: begin
          if (cmp_done) begin
            state <= (cont_q & ~hw_q) ? PH_SAMPLE : PH_IDLE;
            pcnt  <= '0;
          end else if (tick) begin
            pcnt <= pcnt + PW'(1);
          end
        end
      endcase
    end
  end

  assign div_clr   = (state == PH_IDLE) | (state == PH_STAB);
  assign sample_en = (state == PH_SAMPLE);
  assign stab_wait = (state == PH_STAB);
  assign cmp_step  = (state == PH_CMP) & tick;
  assign conv_done = cmp_done;
  assign cmp_bit   = (state == PH_CMP) ? BW'(CMP_LAST - pcnt) : '0;

  assert_phase_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> !cmp_step);

  assert_done_lastbit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (cmp_step && cmp_bit == '0));

  assert_sw_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_sw && !halt) |=> sample_en);

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && cont_q && !hw_q && !halt) |=> sample_en);

  assert_stab_hwonly_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stab_wait |-> hw_q);

  assert_skip_stab_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_hw && cont_q && !first_pend && !halt) |=> (state == PH_SAMPLE));

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (state == PH_IDLE && first_pend));

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl import adc_seq_pkg::*; #(
  parameter  int unsigned PCLK_MHZ    = 16,
  parameter  int unsigned STAB_US     = 2,
  parameter  int unsigned SAMPLE_BASE = 4,
  parameter  int unsigned SAMPLE_EXT  = 8,
  parameter  int unsigned CMP_STEPS   = 12,
  localparam int unsigned BIT_W       = $clog2(CMP_STEPS)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_run,
  input  logic             cfg_cont,
  input  logic             cfg_hwmode,
  input  logic [2:0]       cfg_ratio,
  input  logic             cfg_ext,
  input  logic             sw_start,
  input  logic             hw_trig,
  output logic             busy,
  output logic             stab_wait,
  output logic             sample_en,
  output logic             cmp_step,
  output logic [BIT_W-1:0] cmp_bit,
  output logic             conv_tick,
  output logic             conv_done,
  output logic [2:0]       ratio_q,
  output logic             ext_q,
  output logic             cfg_err,
  output logic             overrun
);

  localparam int unsigned STAB_CYC = stab_cycles(PCLK_MHZ, STAB_US);

  logic       run_q, cont_q, hw_q, halt;
  logic       div_clr, tick;
  adc_phase_e state;
  logic       trig_lost;

  adc_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .run_in   (cfg_run),
    .cont_in  (cfg_cont),
    .hw_in    (cfg_hwmode),
    .ratio_in (cfg_ratio),
    .ext_in   (cfg_ext),
    .run_q    (run_q),
    .cont_q   (cont_q),
    .hw_q     (hw_q),
    .ratio_q  (ratio_q),
    .ext_q    (ext_q),
    .cfg_err  (cfg_err),
    .halt     (halt)
  );

  adc_clk_div u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (div_clr),
    .ratio (ratio_q),
    .tick  (tick)
  );

  adc_phase_fsm #(
    .STAB_CYC    (STAB_CYC),
    .SAMPLE_BASE (SAMPLE_BASE),
    .SAMPLE_EXT  (SAMPLE_EXT),
    .CMP_STEPS   (CMP_STEPS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt      (halt),
    .run_q     (run_q),
    .cont_q    (cont_q),
    .hw_q      (hw_q),
    .ext_q     (ext_q),
    .sw_start  (sw_start),
    .hw_trig   (hw_trig),
    .tick      (tick),
    .state     (state),
    .div_clr   (div_clr),
    .sample_en (sample_en),
    .stab_wait (stab_wait),
    .cmp_step  (cmp_step),
    .conv_done (conv_done),
    .cmp_bit   (cmp_bit)
  );

  assign busy      = (state != PH_IDLE);
  assign conv_tick = tick;
  assign trig_lost = run_q & hw_q & hw_trig & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         overrun <= 1'b0;
    else if (trig_lost) overrun <= 1'b1;
  end

  assert_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && hw_q && hw_trig && busy) |=> overrun);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sample_en && !cmp_step && !conv_tick && !stab_wait));

endmodule

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       i_we = 0, i_run = 0, i_cont = 0, i_hw = 0, i_ext = 0, i_sw = 0, i_trig = 0;
  logic [2:0] i_ratio = 3'd0;

  logic       busy, stab_wait, sample_en, cmp_step, conv_tick, conv_done;
  logic [3:0] cmp_bit;
  logic [2:0] ratio_q;
  logic       ext_q, cfg_err, overrun;

  always #4 clk = ~clk;

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(i_we), .cfg_run(i_run), .cfg_cont(i_cont),
    .cfg_hwmode(i_hw), .cfg_ratio(i_ratio), .cfg_ext(i_ext), .sw_start(i_sw),
    .hw_trig(i_trig), .busy(busy), .stab_wait(stab_wait), .sample_en(sample_en),
    .cmp_step(cmp_step), .cmp_bit(cmp_bit), .conv_tick(conv_tick),
    .conv_done(conv_done), .ratio_q(ratio_q), .ext_q(ext_q), .cfg_err(cfg_err),
    .overrun(overrun)
  );

  localparam int STAB = 32;   // 16 MHz * 2 us

  int n_chk = 0, n_err = 0, cycles = 0;
  int cnt_done = 0, cnt_stab = 0, cnt_tick = 0, cnt_samp = 0;
  string cur_req = "R1";

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_run = 0, m_cont = 0, m_hw = 0, m_ratio = 0, m_ext = 0;
  int m_err = 0, m_ovr = 0, m_first = 1, m_ph = 0, m_e = 0;

  function automatic int ndiv(input int code);
    int d;
    d = 32;
    if (code < 6) for (int k = 0; k < code; k++) d = d / 2;
    return d;
  endfunction

  always @(posedge clk) begin
    int n, sl, halt;
    if (!rst_n) begin
      m_run = 0; m_cont = 0; m_hw = 0; m_ratio = 0; m_ext = 0;
      m_err = 0; m_ovr = 0; m_first = 1; m_ph = 0; m_e = 0;
    end else begin
      n    = ndiv(m_ratio);
      sl   = m_ext ? 8 : 4;
      halt = ((i_we && !i_run) || !m_run) ? 1 : 0;
      if (m_run && m_hw && i_trig && m_ph != 0) m_ovr = 1;
      if (halt) begin
        m_ph = 0; m_e = 0; m_first = 1;
      end else begin
        case (m_ph)
          0: begin
            if (m_hw && i_trig) begin
              m_ph = (!m_cont || m_first) ? 1 : 2; m_e = 0;
            end else if (!m_hw && i_sw) begin
              m_ph = 2; m_e = 0;
            end
          end
          1: if (m_e == STAB - 1) begin
               m_ph = 2; m_e = 0; if (m_cont) m_first = 0;
             end else m_e++;
          2: if (m_e == sl * n - 1) begin m_ph = 3; m_e = 0; end
             else m_e++;
          default: if (m_e == 12 * n - 1) begin
               m_ph = (!m_hw && m_cont) ? 2 : 0; m_e = 0;
             end else m_e++;
        endcase
      end
      if (i_we) begin
        if (!m_run) begin
          m_ratio = int'(i_ratio); m_ext = int'(i_ext);
          if (i_ratio > 3'd5) m_err = 1;
        end
        m_run = int'(i_run); m_cont = int'(i_cont); m_hw = int'(i_hw);
      end
    end
  end

  // per-cycle comparison, sampled 2 ns after the active edge
  always @(posedge clk) begin
    int n;
    logic tk;
    logic [15:0] ev, av;
    cycles++;
    #2;
    if (rst_n) begin
      n  = ndiv(m_ratio);
      tk = (m_ph >= 2) && (m_e % n == n - 1);
      ev = {m_ph != 0, m_ph == 1, m_ph == 2, (m_ph == 3) && tk,
            (m_ph == 3) ? 4'(11 - m_e / n) : 4'd0, tk,
            (m_ph == 3) && (m_e == 12 * n - 1), 3'(m_ratio), m_ext != 0,
            m_err != 0, m_ovr != 0};
      av = {busy, stab_wait, sample_en, cmp_step, cmp_bit, conv_tick, conv_done,
            ratio_q, ext_q, cfg_err, overrun};
      chk(cur_req, "cycle model", 32'(av), 32'(ev));
      if (conv_done) cnt_done++;
      if (stab_wait) cnt_stab++;
      if (conv_tick) cnt_tick++;
      if (sample_en) cnt_samp++;
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 20000) begin
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
    report();
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int k = 1);
    for (int j = 0; j < k; j++) begin
      @(negedge clk); i_we = 0; i_sw = 0; i_trig = 0;
    end
  endtask

  task automatic wr(input logic run, input logic cont, input logic hw, input logic [2:0] ratio, input logic ext);
    @(negedge clk); i_sw = 0; i_trig = 0;
    i_we = 1; i_run = run; i_cont = cont; i_hw = hw; i_ratio = ratio; i_ext = ext;
  endtask

  task automatic start_sw();
    @(negedge clk); i_we = 0; i_trig = 0; i_sw = 1;
  endtask

  task automatic trig();
    @(negedge clk); i_we = 0; i_sw = 0; i_trig = 1;
  endtask

  task automatic clr_cnt();
    cnt_done = 0; cnt_stab = 0; cnt_tick = 0; cnt_samp = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; i_we = 0; i_sw = 0; i_trig = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "outputs in reset", 32'({busy, stab_wait, sample_en, cmp_step, cmp_bit,
        conv_tick, conv_done, ratio_q, ext_q, cfg_err, overrun}), 32'd0);
    rst_n = 1;
    cyc(2);

    // R3 / R5: software single conversion at divide-by-1, extra start while busy
    cur_req = "R3";
    wr(1, 0, 0, 3'd5, 0); cyc(1); clr_cnt();
    start_sw(); cyc(5);
    cur_req = "R5";
    start_sw(); cyc(20);
    chk("R5", "one conversion despite start while busy", 32'(cnt_done), 32'd1);

    // R2: divide-by-4
    cur_req = "R2";
    wr(0, 0, 0, 3'd5, 0); wr(1, 0, 0, 3'd3, 0); cyc(1); clr_cnt();
    start_sw(); cyc(70);
    chk("R2", "ticks per conversion at /4", 32'(cnt_tick), 32'd16);
    chk("R3", "done pulses at /4", 32'(cnt_done), 32'd1);

    // R4: extended sample at divide-by-2
    cur_req = "R4";
    wr(0, 0, 0, 3'd3, 0); wr(1, 0, 0, 3'd4, 1); cyc(1); clr_cnt();
    start_sw(); cyc(50);
    chk("R4", "sample cycles with extension", 32'(cnt_samp), 32'd16);
    chk("R4", "ticks per extended conversion", 32'(cnt_tick), 32'd20);

    // R6: software repeat mode
    cur_req = "R6";
    wr(0, 0, 0, 3'd4, 1); wr(1, 1, 0, 3'd5, 0); cyc(1); clr_cnt();
    start_sw(); cyc(64);
    chk("R6", "back-to-back dones in 64 cycles", 32'(cnt_done), 32'd4);
    wr(0, 0, 0, 3'd5, 0); cyc(1);

    // R7: trigger-wait single mode
    cur_req = "R7";
    wr(1, 0, 1, 3'd5, 0); cyc(1); clr_cnt();
    start_sw(); cyc(3);
    chk("R7", "sw_start ignored in trigger mode", 32'(busy), 32'd0);
    trig(); cyc(60); trig(); cyc(60);
    chk("R7", "settling cycles for two triggers", 32'(cnt_stab), 32'(2 * STAB));
    chk("R7", "two conversions", 32'(cnt_done), 32'd2);

    // R8: trigger-wait repeat mode
    cur_req = "R8";
    wr(0, 0, 1, 3'd5, 0); wr(1, 1, 1, 3'd5, 0); cyc(1); clr_cnt();
    trig(); cyc(60); trig(); cyc(30);
    chk("R8", "settling only once", 32'(cnt_stab), 32'(STAB));
    chk("R8", "two conversions", 32'(cnt_done), 32'd2);

    // R9: trigger while busy
    cur_req = "R9";
    trig(); cyc(5); trig(); cyc(20);
    chk("R9", "overrun after busy trigger", 32'(overrun), 32'd1);

    // R9: trigger exactly in the conv_done cycle
    do_reset();
    wr(1, 1, 1, 3'd5, 0); cyc(1);
    trig(); cyc(47); trig(); cyc(3);
    chk("R9", "overrun on done-cycle trigger", 32'(overrun), 32'd1);
    chk("R9", "done-cycle trigger not started", 32'(busy), 32'd0);

    // R10: abort mid-sample, re-arm settling
    cur_req = "R10";
    trig(); cyc(3);
    wr(0, 1, 1, 3'd5, 0); cyc(1);
    chk("R10", "idle after disable", 32'(busy), 32'd0);
    wr(1, 1, 1, 3'd5, 0); cyc(1); clr_cnt();
    trig(); cyc(50);
    chk("R10", "settling re-armed", 32'(cnt_stab), 32'(STAB));

    // R11: timing fields frozen while enabled
    cur_req = "R11";
    wr(1, 1, 1, 3'd2, 1); cyc(2);
    chk("R11", "ratio unchanged while enabled", 32'(ratio_q), 32'd5);
    chk("R11", "extension unchanged while enabled", 32'(ext_q), 32'd0);

    // R2: reserved ratio code
    cur_req = "R2";
    wr(0, 0, 0, 3'd5, 0); wr(1, 0, 0, 3'd6, 0); cyc(1);
    chk("R2", "reserved code flags error", 32'(cfg_err), 32'd1);
    clr_cnt();
    start_sw(); cyc(520);
    chk("R2", "reserved code runs at /32", 32'(cnt_tick), 32'd16);
    chk("R2", "one conversion at /32", 32'(cnt_done), 32'd1);

    report();
  end

endmodule